// File: doc/BRIEF.md
# Capture Timer with Edge-Latched Count

This peripheral holds a free-running up-counter that software starts, stops, loads and reads through a simple word-addressed register port. A single external event line is brought into the timer clock domain, and a selected transition on it copies the running count into a capture register. Because the count is latched in hardware, the timestamp keeps its accuracy however late software gets round to reading it. A typical use is timestamping a once-per-second reference pulse against a system-clock count.

Two events are flagged: a capture and a counter wrap. Both flags are always visible in the raw status word. A separate enable word decides which of them reach the interrupt line, and flags are cleared only through the masked status word. A soft-reset command clears the whole block over a fixed number of cycles and reports busy while it runs. The event pad is modelled as three signals. The block drives the pad's output enable until software selects input mode, and the output value it drives is always low.

Top module: `edge_capture_timer`

## Requirements
- R1: After the reset input is released, every register reads zero, `irq` is low and `evt_oe` is high.
- R2: While control bit 0 (run) is set, the count rises by one every clock. While it is clear, the count holds.
- R3: When a running count is all ones, the next count is the load register (word 2) if control bit 1 (reload) is set, or zero if it is clear. In either case raw status bit 1 (wrap) is set.
- R4: A write to word 1 sets the count to the written value at any time. This write takes priority over counting.
- R5: `evt_in` passes through two synchroniser flops. An edge seen by the synchronised sample causes a capture in the third clock after the pin changes. The capture stores the count value of that cycle in word 3 and sets raw status bit 0 (captured).
- R6: Control bits 3:2 select the capture edge: 00 none, 01 rising, 10 falling, 11 both. Both edge types set the same single captured flag.
- R7: While the captured flag is set, further edges leave word 3 unchanged.
- R8: Word 4 (raw status) shows both flags whatever the enable word (word 6) holds. Writes to word 4 have no effect.
- R9: Word 5 reads raw status AND enable. Writing 1 to a bit of word 5 clears that flag. `irq` is high exactly when word 5 is non-zero.
- R10: Control bit 4 (pin input) set drives `evt_oe` low. Clear drives it high. `evt_out` is always low.
- R11: Writing 1 to bit 0 of word 7 starts a soft reset. Word 7 bit 0 then reads 1 for 4 cycles. During that time all registers are zero and register writes are ignored. Afterwards the registers stay zero until they are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_in | input | 1 | Event pad input level |
| evt_out | output | 1 | Event pad output level (always low) |
| evt_oe | output | 1 | Event pad output enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench freezes the counter at known values so that each captured timestamp has an exact expected value. It then fires edges in every select mode. A design with inverted edge logic, or one that fires on the unsynchronised pin, latches the wrong count or no count at all. A second edge while the captured flag is still set targets the hold rule: a design that keeps overwriting would report the later timestamp. The bench writes to the raw status word, and to the masked word with the interrupt disabled, to catch flags that are cleared from the wrong address. It writes to registers during the soft reset to catch a reset that lets writes leak through.

// File: rtl/edge_capture_timer.sv
module edge_capture_timer #(
  parameter int W = 32,
  parameter int RST_CYC = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_we,
  input  logic [2:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         evt_in,
  output logic         evt_out,
  output logic         evt_oe,
  output logic         irq
);
  localparam int RCW = $clog2(RST_CYC + 1);

  logic [4:0]   ctrl;
  logic [W-1:0] cnt, ld, cap;
  logic [1:0]   raw, ien, raw_nxt;
  logic [2:0]   syn;
  logic [RCW-1:0] rst_cnt;
  logic busy, go, rise, fall, hit;

  assign busy = |rst_cnt;
  assign go   = reg_we && !busy && reg_addr == 3'd7 && reg_wdata[0];
  assign rise = syn[1] & ~syn[2];
  assign fall = ~syn[1] & syn[2];
  assign hit  = (ctrl[2] & rise) | (ctrl[3] & fall);

  function automatic logic wr(input logic [2:0] a);
    return reg_we && !busy && reg_addr == a;
  endfunction

  always_comb begin
    raw_nxt = raw;
    if (wr(3'd5)) raw_nxt = raw_nxt & ~reg_wdata[1:0];
    if (hit && !raw[0]) raw_nxt[0] = 1'b1;
    if (!wr(3'd1) && ctrl[0] && &cnt) raw_nxt[1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_cnt <= '0;
    else if (go) rst_cnt <= RCW'(RST_CYC);
    else if (busy) rst_cnt <= rst_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; cnt <= '0; ld <= '0; cap <= '0;
      raw <= '0; ien <= '0; syn <= '0;
    end else if (go || busy) begin
      ctrl <= '0; cnt <= '0; ld <= '0; cap <= '0;
      raw <= '0; ien <= '0; syn <= '0;
    end else begin
      syn <= {syn[1:0], evt_in};
      raw <= raw_nxt;
      if (hit && !raw[0]) cap <= cnt;
      if (wr(3'd1)) cnt <= reg_wdata;
      else if (ctrl[0]) cnt <= (&cnt) ? (ctrl[1] ? ld : '0) : cnt + 1'b1;
      if (wr(3'd0)) ctrl <= reg_wdata[4:0];
      if (wr(3'd2)) ld <= reg_wdata;
      if (wr(3'd6)) ien <= reg_wdata[1:0];
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0: reg_rdata = W'(ctrl);
      3'd1: reg_rdata = cnt;
      3'd2: reg_rdata = ld;
      3'd3: reg_rdata = cap;
      3'd4: reg_rdata = W'(raw);
      3'd5: reg_rdata = W'(raw & ien);
      3'd6: reg_rdata = W'(ien);
      default: reg_rdata = W'(busy);
    endcase
  end

  assign evt_out = 1'b0;
  assign evt_oe  = ~ctrl[4];
  assign irq     = |(raw & ien);
endmodule

module edge_capture_timer_chk #(
  parameter int W = 32,
  parameter int RCW = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_we,
  input logic [2:0]   reg_addr,
  input logic [W-1:0] reg_wdata,
  input logic [4:0]   ctrl,
  input logic [W-1:0] cnt,
  input logic [W-1:0] cap,
  input logic [1:0]   raw,
  input logic [RCW-1:0] rst_cnt
);
  logic idle, cwr;
  assign idle = rst_cnt == '0 && !(reg_we && reg_addr == 3'd7 && reg_wdata[0]);
  assign cwr  = reg_we && reg_addr == 3'd1;

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle && ctrl[0] && !cwr && !(&cnt) |=> cnt == $past(cnt) + 1'b1);
  // R3
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle && ctrl[0] && !cwr && (&cnt) |=> raw[1]);
  // R4
  cnt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle && cwr |=> cnt == $past(reg_wdata));
  // R7
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle && raw[0] |=> $stable(cap));
  // R11
  busy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cnt != '0 |-> cnt == '0 && ctrl == '0 && raw == '0);
endmodule

bind edge_capture_timer edge_capture_timer_chk #(.W(W), .RCW(RCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ctrl(ctrl), .cnt(cnt), .cap(cap), .raw(raw),
  .rst_cnt(rst_cnt));

// File: tb/test_edge_capture_timer.sv
module test_edge_capture_timer;
  logic clk = 0, rst_n = 0, we = 0, pin = 0;
  logic [2:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic evt_out, evt_oe, irq;
  int tests = 0, fails = 0;
  bit live = 0, done = 0;

  always #4 clk = ~clk;

  edge_capture_timer i_edge_capture_timer (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .evt_in(pin), .evt_out(evt_out), .evt_oe(evt_oe), .irq(irq));

  // behavioural reference
  logic [31:0] m_ctrl, m_cnt, m_ld, m_cap, m_raw, m_ien;
  int m_busy;
  bit q[$] = '{0, 0, 0};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mread(logic [2:0] a);
    case (a)
      0: return m_ctrl;
      1: return m_cnt;
      2: return m_ld;
      3: return m_cap;
      4: return m_raw;
      5: return m_raw & m_ien;
      6: return m_ien;
      default: return (m_busy > 0) ? 1 : 0;
    endcase
  endfunction

  function automatic string tagof(logic [2:0] a);
    case (a)
      0: return "R6";
      1: return "R2";
      2: return "R3";
      3: return "R5";
      4: return "R8";
      5: return "R9";
      6: return "R9";
      default: return "R11";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_cnt = 0; m_ld = 0; m_cap = 0; m_raw = 0; m_ien = 0;
      m_busy = 0; q = '{0, 0, 0};
    end else if (m_busy > 0 || (we && addr == 7 && wdata[0])) begin
      m_busy = (m_busy > 0) ? m_busy - 1 : 4;
      m_ctrl = 0; m_cnt = 0; m_ld = 0; m_cap = 0; m_raw = 0; m_ien = 0;
      q = '{0, 0, 0};
    end else begin
      logic [31:0] old_raw;
      bit edge_ok;
      old_raw = m_raw;
      edge_ok = (m_ctrl[2] && q[1] && !q[2]) || (m_ctrl[3] && !q[1] && q[2]);
      if (we && addr == 5) m_raw = m_raw & ~(wdata & 32'h3);
      if (edge_ok && !old_raw[0]) begin m_cap = m_cnt; m_raw[0] = 1; end
      if (we && addr == 1) m_cnt = wdata;
      else if (m_ctrl[0]) begin
        if (m_cnt == 32'hFFFF_FFFF) begin
          m_cnt = m_ctrl[1] ? m_ld : 0;
          m_raw[1] = 1;
        end else m_cnt = m_cnt + 1;
      end
      if (we && addr == 0) m_ctrl = wdata & 32'h1F;
      if (we && addr == 2) m_ld = wdata;
      if (we && addr == 6) m_ien = wdata & 32'h3;
      q.push_front(pin);
      void'(q.pop_back());
    end
  end

  always @(negedge clk) if (live) begin
    chk(tagof(addr), rdata, mread(addr));
    chk("R9", irq, |(m_raw & m_ien));
    chk("R10", evt_oe, !m_ctrl[4]);
    chk("R10", evt_out, 0);
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #2; we = 0; end
  endtask
  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(posedge clk); #2; we = 1; addr = a; wdata = d;
    @(posedge clk); #2; we = 0;
  endtask
  task automatic rd(logic [2:0] a, output logic [31:0] v);
    @(posedge clk); #2; we = 0; addr = a;
    @(negedge clk); v = rdata;
  endtask
  task automatic setpin(bit v);
    @(posedge clk); #2; pin = v;
    tick(4);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, first;
    tick(3); #1 rst_n = 1; live = 1;
    // R1
    for (int a = 0; a < 8; a++) begin rd(3'(a), v); chk("R1", v, 0); end
    chk("R1", evt_oe, 1); chk("R1", irq, 0);
    // R2: run then stop
    wr(2, 32'h10); wr(0, 32'h3); tick(10);
    wr(0, 32'h0); rd(1, v); tick(3); rd(1, first); chk("R2", first, v);
    // R3 / R4: wrap with reload, then without
    wr(1, 32'hFFFF_FFFD); wr(0, 32'h3); tick(4); wr(0, 0);
    rd(4, v); chk("R3", v[1], 1);
    wr(5, 32'h2); wr(1, 32'hFFFF_FFFE); wr(0, 32'h1); tick(4); wr(0, 0);
    rd(1, v); chk("R3", v < 32'h10, 1);
    wr(5, 32'h2);
    // R5 / R6 rising, counter frozen
    wr(1, 32'h1234_5678); rd(1, v); chk("R4", v, 32'h1234_5678);
    wr(0, 32'h4); setpin(1);
    rd(3, v); chk("R5", v, 32'h1234_5678);
    rd(4, v); chk("R8", v, 1); chk("R8", irq, 0);
    rd(5, v); chk("R9", v, 0);
    // R7: second edge does not overwrite
    wr(1, 32'hAAAA_0000); setpin(0); setpin(1);
    rd(3, v); chk("R7", v, 32'h1234_5678);
    // R8: raw write ignored; R9 clear via masked word
    wr(4, 32'h3); rd(4, v); chk("R8", v, 1);
    wr(6, 32'h1); tick(1); chk("R9", irq, 1);
    wr(5, 32'h1); rd(4, v); chk("R9", v, 0); chk("R9", irq, 0);
    // R6 falling
    wr(0, 32'h8); wr(1, 32'h55); setpin(0);
    rd(3, v); chk("R6", v, 32'h55); wr(5, 1);
    // R6 none
    wr(0, 32'h0); wr(1, 32'h66); setpin(1); setpin(0);
    rd(4, v); chk("R6", v, 0);
    // R6 both
    wr(0, 32'hC); wr(1, 32'h77); setpin(1); rd(3, v); chk("R6", v, 32'h77);
    wr(5, 1); wr(1, 32'h88); setpin(0); rd(3, v); chk("R6", v, 32'h88);
    // R10 pin direction
    wr(0, 32'h10); tick(1); chk("R10", evt_oe, 0);
    // running capture compared against the model each cycle
    wr(5, 3); wr(0, 32'h5); setpin(1); tick(3); wr(0, 0);
    // R11 soft reset
    wr(2, 32'h99); wr(7, 1); rd(7, v); chk("R11", v, 1);
    @(posedge clk); #2; we = 1; addr = 2; wdata = 32'h42; tick(1);
    tick(4); rd(7, v); chk("R11", v, 0);
    rd(2, v); chk("R11", v, 0); rd(0, v); chk("R11", v, 0);
    chk("R11", evt_oe, 1);
    tick(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule